// File: doc/BRIEF.md
# Chained Descriptor Walker

This block sequences one DMA channel through a list of transfer descriptors kept in memory. Software writes the address of the first descriptor. The walker then reads each descriptor as two 32-bit words over a simple request/response read port and checks the descriptor. It hands each buffer (address, length) to an external data mover and waits for the mover's done strobe. After that it moves 8 bytes on to the next descriptor. The walk ends after the descriptor that carries the last flag, and a one-cycle completion pulse goes to the interrupt logic.

The channel has two modes, selected by a static input. In transmit mode, the write of the start address launches the walk. In receive mode, that write only arms the channel. The walk begins once the enable input is high, and dropping the enable stops a running walk. A descriptor that fails its checks ends the walk with an error pulse and no completion pulse.

Top module: `desc_list_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `rd_req`, `mv_cmd_valid`, `done_pulse` and `err_pulse` are all low.
- R2: In transmit mode (`rx_mode`=0), a `start_wr` pulse while idle starts a walk. The first read goes to `start_addr` and the second read goes to `start_addr`+4.
- R3: The first descriptor word carries the flags in bits [7:0] and the byte length in bits [31:16]. The second word is the buffer address. Each accepted descriptor produces a single-cycle `mv_cmd_valid` with `mv_addr` and `mv_len` taken from those fields.
- R4: After the mover's done strobe for a descriptor whose last flag (flag bit 1) is clear, the next descriptor is fetched 8 bytes further on. The walk stops after the descriptor whose last flag is set.
- R5: `done_pulse` is high for exactly one cycle, in the cycle after the clock edge that captures `mv_done` for the last descriptor. It fires exactly once per walk.
- R6: A descriptor with flag bit 0 (valid) clear, or flag bit 5 (transfer) clear, issues no mover command. It produces one `err_pulse`, no `done_pulse`, and the walker returns to idle.
- R7: A descriptor whose length is not a multiple of 4 is rejected in the same way as in R6. A command issued before the bad descriptor in the same list still goes out.
- R8: In receive mode (`rx_mode`=1), `start_wr` with `rx_enable` low issues no read. The walk begins once `rx_enable` goes high.
- R9: In receive mode, a low `rx_enable` during a walk returns the walker to idle. It gives neither `done_pulse` nor `err_pulse`.
- R10: A `start_wr` while the walker is busy is ignored. No read is ever issued to the address it carried.
- R11: `mv_row` equals `row_bytes` in receive mode and zero in transmit mode.
- R12: Once raised, `rd_req` stays high with a stable `rd_addr` until `rd_valid` arrives, unless a receive abort (R9) intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode | input | 1 | 1 = receive channel, 0 = transmit channel (static) |
| start_wr | input | 1 | Write strobe of the start address |
| start_addr | input | 32 | Address of the first descriptor |
| rx_enable | input | 1 | Receive enable level |
| row_bytes | input | ROW_W | Bytes per row for line-structured receive |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 32 | Read response data |
| mv_cmd_valid | output | 1 | Buffer command strobe to the data mover |
| mv_addr | output | 32 | Buffer address |
| mv_len | output | 16 | Buffer length in bytes |
| mv_row | output | ROW_W | Row size passed to the mover |
| mv_done | input | 1 | Mover finished the current buffer |
| busy | output | 1 | Walk in progress |
| done_pulse | output | 1 | List completed |
| err_pulse | output | 1 | Walk aborted on a bad descriptor |

## Verification
The walker is driven with four kinds of list, each of which separates a different fault:
- A single-entry list shows whether the two descriptor words are read from the right addresses and decoded into the right fields.
- A three-entry chain shows the 8-byte step and that only the entry carrying the last flag ends the walk.
- Lists with a cleared valid bit, a cleared transfer bit, an unaligned length, or a bad second entry separate each rejection path from the completion path.
- Receive-mode runs show that arming and launching are separate, and they exercise the enable-driven abort and the row size passed to the mover. A start written while busy is used to tell ignored requests apart from ones that are queued or that restart the walk.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int ADDR_W     = 32;
  localparam int LEN_W      = 16;
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 4;

  localparam int FLG_VALID = 0;
  localparam int FLG_LAST  = 1;
  localparam int FLG_XFER  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_LO, ST_FETCH_HI, ST_CHECK, ST_XFER, ST_DONE, ST_FAULT
  } dw_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] buf_addr;
    logic [LEN_W-1:0]  len;
    logic [7:0]        spare;
    logic [7:0]        flags;
  } dw_desc_t;
endpackage

// File: rtl/dw_desc_decode.sv
module dw_desc_decode
  import dw_pkg::*;
#(
  parameter int LEN_ALIGN = 4
) (
  input  logic [31:0] word_lo,
  input  logic [31:0] word_hi,
  output dw_desc_t    desc,
  output logic        fault
);
  localparam int ALIGN_BITS = $clog2(LEN_ALIGN);

  logic misaligned;

  assign desc = {word_hi, word_lo};

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign misaligned = |desc.len[ALIGN_BITS-1:0];
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  assign fault = !desc.flags[FLG_VALID] || !desc.flags[FLG_XFER] || misaligned;
endmodule

// File: rtl/dw_ptr.sv
module dw_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (adv) begin
      ptr <= ptr + AW'(STEP);
    end
  end
endmodule

// File: rtl/desc_list_walker.sv
module desc_list_walker
  import dw_pkg::*;
#(
  parameter int ROW_W     = 16,
  parameter int LEN_ALIGN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              start_wr,
  input  logic [31:0]       start_addr,
  input  logic              rx_enable,
  input  logic [ROW_W-1:0]  row_bytes,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              mv_cmd_valid,
  output logic [31:0]       mv_addr,
  output logic [15:0]       mv_len,
  output logic [ROW_W-1:0]  mv_row,
  input  logic              mv_done,
  output logic              busy,
  output logic              done_pulse,
  output logic              err_pulse
);
  localparam int HALF = DESC_BYTES / 2;

  dw_state_t   state_q, state_d;
  logic [31:0] word_lo_q, word_hi_q;
  logic        armed_q, armed_d;
  logic        idle, launch, abort, ptr_load, ptr_adv;
  logic        cap_lo, cap_hi;
  logic [31:0] ptr;
  dw_desc_t    desc;
  logic        fault;

  assign idle     = (state_q == ST_IDLE);
  assign launch   = idle && (rx_mode ? (armed_q && rx_enable) : start_wr);
  assign abort    = !idle && rx_mode && !rx_enable;
  assign ptr_load = idle && start_wr;
  assign cap_lo   = (state_q == ST_FETCH_LO) && rd_valid;
  assign cap_hi   = (state_q == ST_FETCH_HI) && rd_valid;
  assign ptr_adv  = (state_q == ST_XFER) && mv_done && !desc.flags[FLG_LAST] && !abort;

  dw_ptr #(.AW(32), .STEP(DESC_BYTES)) i_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(start_addr),
    .adv(ptr_adv), .ptr(ptr)
  );

  dw_desc_decode #(.LEN_ALIGN(LEN_ALIGN)) i_dec (
    .word_lo(word_lo_q), .word_hi(word_hi_q), .desc(desc), .fault(fault)
  );

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    if (idle && start_wr && rx_mode) armed_d = 1'b1;
    if (!idle) armed_d = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (launch) state_d = ST_FETCH_LO;
      ST_FETCH_LO: if (rd_valid) state_d = ST_FETCH_HI;
      ST_FETCH_HI: if (rd_valid) state_d = ST_CHECK;
      ST_CHECK:    state_d = fault ? ST_FAULT : ST_XFER;
      ST_XFER:     if (mv_done) state_d = desc.flags[FLG_LAST] ? ST_DONE : ST_FETCH_LO;
      ST_DONE:     state_d = ST_IDLE;
      ST_FAULT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_lo_q <= '0;
    end else if (cap_lo) begin
      word_lo_q <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_hi_q <= '0;
    end else if (cap_hi) begin
      word_hi_q <= rd_data;
    end
  end

  assign rd_req       = (state_q == ST_FETCH_LO) || (state_q == ST_FETCH_HI);
  assign rd_addr      = ptr + ((state_q == ST_FETCH_HI) ? 32'(HALF) : 32'd0);
  assign mv_cmd_valid = (state_q == ST_CHECK) && !fault;
  assign mv_addr      = desc.buf_addr;
  assign mv_len       = desc.len;
  assign mv_row       = rx_mode ? row_bytes : '0;
  assign busy         = !idle;
  assign done_pulse   = (state_q == ST_DONE);
  assign err_pulse    = (state_q == ST_FAULT);
endmodule

// File: rtl/dw_walker_chk.sv
module dw_walker_chk #(
  parameter int ROW_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_mode,
  input logic        rx_enable,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic        rd_valid,
  input logic        mv_cmd_valid,
  input logic [15:0] mv_len,
  input logic        mv_done,
  input logic        busy,
  input logic        done_pulse
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !mv_cmd_valid));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && !(rx_mode && !rx_enable)) |=> (rd_req && $stable(rd_addr)));

  a_r7_len_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mv_cmd_valid |-> (mv_len[1:0] == 2'b00));

  a_r3_cmd_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mv_cmd_valid |-> $past(rd_valid));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r5_done_after_mover: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(mv_done));
endmodule

bind desc_list_walker dw_walker_chk #(.ROW_W(ROW_W)) i_dw_walker_chk (.*);

// File: tb/test_desc_list_walker.sv
module test_desc_list_walker;
  localparam int ROW_W = 16;
  localparam int RD_LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_mode = 1'b0, start_wr = 1'b0, rx_enable = 1'b0;
  logic [31:0] start_addr = '0;
  logic [ROW_W-1:0] row_bytes = 16'h0280;
  logic rd_req, rd_valid = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic mv_cmd_valid, mv_done = 1'b0;
  logic [31:0] mv_addr;
  logic [15:0] mv_len;
  logic [ROW_W-1:0] mv_row;
  logic busy, done_pulse, err_pulse;

  always #4 clk = ~clk;

  desc_list_walker #(.ROW_W(ROW_W)) i_desc_list_walker (.*);

  logic [31:0] mem [0:63];
  logic [31:0] rd_log [0:31];
  logic [31:0] cmd_addr [0:15];
  logic [15:0] cmd_len [0:15];
  logic [15:0] cmd_row [0:15];
  int rd_n, cmd_n, done_n, err_n, hold_bad, cyc, mvd_cyc, done_gap;
  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_n = 0; cmd_n = 0; done_n = 0; err_n = 0; hold_bad = 0; done_gap = -1;
  endtask

  task automatic put_desc(int base, logic [7:0] flg, logic [15:0] len, logic [31:0] a);
    mem[base[7:2]]     = {len, 8'h00, flg};
    mem[base[7:2] + 1] = a;
  endtask

  task automatic kick(logic [31:0] a);
    @(negedge clk); start_addr = a; start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // memory responder
  initial begin
    int cnt = 0;
    logic [31:0] first_addr = '0;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        rd_valid = 1'b0; cnt = 0;
      end else if (rd_req) begin
        if (cnt == 0) first_addr = rd_addr;
        if (cnt == RD_LAT) begin
          if (rd_addr !== first_addr) hold_bad++;
          rd_data = mem[rd_addr[7:2]];
          rd_log[rd_n[4:0]] = rd_addr;
          rd_n++;
          rd_valid = 1'b1; cnt = 0;
        end else cnt++;
      end else cnt = 0;
    end
  end

  // data mover model
  initial begin
    forever begin
      @(negedge clk);
      mv_done = 1'b0;
      if (mv_cmd_valid) begin
        cmd_addr[cmd_n[3:0]] = mv_addr;
        cmd_len[cmd_n[3:0]]  = mv_len;
        cmd_row[cmd_n[3:0]]  = mv_row;
        cmd_n++;
        repeat (3) @(negedge clk);
        mv_done = 1'b1;
      end
    end
  end

  // output monitor, sampled 1 ns after the rising edge
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (mv_done) mvd_cyc = cyc;
      if (done_pulse) begin done_n++; done_gap = cyc - mvd_cyc; end
      if (err_pulse) err_n++;
    end
  end

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 rd_req", rd_req, 0);
    check("R1 cmd", mv_cmd_valid, 0);
    check("R1 done/err", {done_pulse, err_pulse}, 0);
  endtask

  task automatic t_single_tx();
    clear_logs();
    put_desc(32'h1000, 8'h23, 16'h0040, 32'hA000_0010);
    kick(32'h1000);
    wait_idle();
    check("R2 rd count", rd_n, 2);
    check("R2 first rd", rd_log[0], 32'h1000);
    check("R2 second rd", rd_log[1], 32'h1004);
    check("R3 cmd count", cmd_n, 1);
    check("R3 cmd addr", cmd_addr[0], 32'hA000_0010);
    check("R3 cmd len", cmd_len[0], 16'h0040);
    check("R11 tx row", cmd_row[0], 0);
    check("R5 done count", done_n, 1);
    check("R5 done timing", done_gap, 0);
    check("R6 no err", err_n, 0);
    check("R12 addr hold", hold_bad, 0);
  endtask

  task automatic t_chain();
    clear_logs();
    put_desc(32'h1040, 8'h21, 16'h0010, 32'hB000_0000);
    put_desc(32'h1048, 8'h21, 16'h0020, 32'hB000_1000);
    put_desc(32'h1050, 8'h23, 16'h0030, 32'hB000_2000);
    kick(32'h1040);
    wait_idle();
    check("R4 rd count", rd_n, 6);
    for (int i = 0; i < 6; i++) check("R4 rd step", rd_log[i], 32'h1040 + 32'(4 * i));
    check("R4 cmd count", cmd_n, 3);
    for (int i = 0; i < 3; i++) begin
      check("R4 cmd addr", cmd_addr[i], 32'hB000_0000 + 32'(i * 32'h1000));
      check("R4 cmd len", cmd_len[i], 16'(16 * (i + 1)));
    end
    check("R5 done once", done_n, 1);
    check("R12 addr hold", hold_bad, 0);
  endtask

  task automatic t_bad_flags();
    clear_logs();
    put_desc(32'h1080, 8'h22, 16'h0010, 32'hC000_0000);
    kick(32'h1080);
    wait_idle();
    check("R6 no valid: cmd", cmd_n, 0);
    check("R6 no valid: err", err_n, 1);
    check("R6 no valid: done", done_n, 0);
    clear_logs();
    put_desc(32'h1080, 8'h03, 16'h0010, 32'hC000_0000);
    kick(32'h1080);
    wait_idle();
    check("R6 no xfer: cmd", cmd_n, 0);
    check("R6 no xfer: err", err_n, 1);
    check("R6 no xfer: busy", busy, 0);
  endtask

  task automatic t_bad_len();
    clear_logs();
    put_desc(32'h10C0, 8'h23, 16'h0042, 32'hD000_0000);
    kick(32'h10C0);
    wait_idle();
    check("R7 odd len: cmd", cmd_n, 0);
    check("R7 odd len: err", err_n, 1);
    clear_logs();
    put_desc(32'h10C0, 8'h21, 16'h0008, 32'hD000_0000);
    put_desc(32'h10C8, 8'h23, 16'h0006, 32'hD000_0100);
    kick(32'h10C0);
    wait_idle();
    check("R7 second bad: cmd", cmd_n, 1);
    check("R7 second bad: err", err_n, 1);
    check("R7 second bad: done", done_n, 0);
  endtask

  task automatic t_rx_start();
    clear_logs();
    rx_mode = 1'b1;
    put_desc(32'h1000, 8'h23, 16'h0100, 32'hE000_0000);
    kick(32'h1000);
    repeat (20) @(negedge clk);
    check("R8 armed no read", rd_n, 0);
    check("R8 armed idle", busy, 0);
    rx_enable = 1'b1;
    wait_idle();
    check("R8 enabled reads", rd_n, 2);
    check("R8 cmd", cmd_n, 1);
    check("R11 rx row", cmd_row[0], 16'h0280);
    check("R8 done", done_n, 1);
  endtask

  task automatic t_rx_abort();
    clear_logs();
    put_desc(32'h1040, 8'h21, 16'h0010, 32'hB000_0000);
    put_desc(32'h1048, 8'h23, 16'h0020, 32'hB000_1000);
    kick(32'h1040);
    for (int i = 0; i < 200 && cmd_n == 0; i++) @(negedge clk);
    rx_enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 abort idle", busy, 0);
    repeat (10) @(negedge clk);
    check("R9 no done", done_n, 0);
    check("R9 no err", err_n, 0);
    check("R9 no more reads", rd_n, 2);
    rx_mode = 1'b0;
  endtask

  task automatic t_busy_ignore();
    clear_logs();
    put_desc(32'h1000, 8'h23, 16'h0040, 32'hA000_0010);
    put_desc(32'h1080, 8'h23, 16'h0040, 32'hF000_0000);
    kick(32'h1000);
    repeat (3) @(negedge clk);
    kick(32'h1080);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R10 reads", rd_n, 2);
    check("R10 first rd", rd_log[0], 32'h1000);
    check("R10 cmd addr", cmd_addr[0], 32'hA000_0010);
    check("R10 cmd count", cmd_n, 1);
    check("R10 done once", done_n, 1);
    check("R10 stays idle", busy, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung, expected end of run");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    clear_logs();
    mvd_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_tx();
    t_chain();
    t_bad_flags();
    t_bad_len();
    t_rx_start();
    t_rx_abort();
    t_busy_ignore();
    finish_run();
  end
endmodule